// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital side of a single-channel voltage-output converter. A host sends it fixed 16-bit words over a three-wire serial link made of an active-low select, a serial clock and a data line. The block samples all three lines into its own system clock domain. It shifts in data bits on falling clock edges while select is low and counts them. When the sixteenth bit arrives, it captures the whole word.

The four leading bits of each word are an opcode. Opcode `0000` moves the data field into the converter code register. Opcode `1111` changes the output termination instead, using the two lowest bits of the word. The host sees a word in an input latch first and the result in the code register afterwards, so the code register is double buffered. The converter resolution is a parameter, and the data field is packed to the left of the twelve payload bits.

After a complete word, the block ignores further clock edges until select goes high and low again. A frame that ends early is thrown away.

Top module: `serdac_cmd_if`

## Requirements
- R1: After reset, `dac_code_o` is all zeros and `out_mode_o` is `00` (output driven).
- R2: A complete word with opcode bits [15:12] = `0000` loads the data field into `dac_code_o`; at 12-bit width the field is word bits [11:0]. `out_mode_o` is left unchanged.
- R3: At 10-bit width the data field is word bits [11:2], and at 8-bit width it is word bits [11:4]; bits [3:2] have no effect at 8-bit width.
- R4: A complete word with opcode `1111` sets `out_mode_o` to word bits [1:0] and leaves `dac_code_o` unchanged. The encodings are `00` driven, `01` floating, `10` 1 kΩ to ground and `11` 100 kΩ to ground.
- R5: A complete word with any opcode other than `0000` or `1111` changes neither output.
- R6: If select rises before the sixteenth falling edge, the partial word is discarded. The next framed word is then received from its first bit.
- R7: After the sixteenth falling edge of a frame, further edges are ignored until select has gone high and then low again.
- R8: Serial clock edges while select is high are ignored and do not advance the bit count.
- R9: Fifteen falling edges with select held low change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n_i | input | 1 | Serial select, active low, asynchronous to clk |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdin_i | input | 1 | Serial data, most significant bit first |
| dac_code_o | output | DATA_W | Converter code register |
| out_mode_o | output | 2 | Output termination selector |

## Verification
A bit counter that is off by one shows up as a shifted code on `dac_code_o`, or as a load that never happens. This becomes visible a few system clocks after the sixteenth serial edge. A lock flag that is not set or not cleared shows up on the next frame, either as a second load from trailing bits or as a valid word that is refused. Decode faults appear on the same cycle as the code register update: a wrong field offset, a bad opcode compare, or a mode command that also touches the code. Running three resolutions side by side on the same wire stimulus exposes any error in the packing.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int FRAME_W = 16;
  localparam int OP_W    = 4;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    TERM_DRIVE = 2'b00,
    TERM_FLOAT = 2'b01,
    TERM_R1K   = 2'b10,
    TERM_R100K = 2'b11
  } term_e;

  localparam logic [OP_W-1:0] OP_LOAD = 4'h0;
  localparam logic [OP_W-1:0] OP_TERM = 4'hF;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= RST_VAL;
    else        stg_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= RST_VAL;
      else        stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter
  import serdac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_s,
  input  logic               sclk_s,
  input  logic               sdin_s,
  output logic [FRAME_W-1:0] word_o,
  output logic               word_vld_o
);
  logic               sclk_prev_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               locked_q, locked_d;
  logic               vld_q, vld_d;
  logic               fall, take;

  assign fall = sclk_prev_q & ~sclk_s;
  assign take = fall & ~cs_n_s & ~locked_q;

  always_comb begin
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    locked_d = locked_q;
    vld_d    = 1'b0;
    if (cs_n_s) begin
      cnt_d    = '0;
      locked_d = 1'b0;
    end else if (take) begin
      shreg_d = {shreg_q[FRAME_W-2:0], sdin_s};
      if (cnt_q == CNT_W'(FRAME_W - 1)) begin
        cnt_d    = '0;
        locked_d = 1'b1;
        vld_d    = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      shreg_q     <= '0;
      locked_q    <= 1'b0;
      vld_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      cnt_q       <= cnt_d;
      shreg_q     <= shreg_d;
      locked_q    <= locked_d;
      vld_q       <= vld_d;
    end
  end

  assign word_o     = shreg_q;
  assign word_vld_o = vld_q;

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt_q == '0 && !vld_q));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !cs_n_s) |=> !vld_q);

  // R7
  vld_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> locked_q);
endmodule

// File: rtl/serdac_decode.sv
module serdac_decode
  import serdac_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               word_vld_i,
  output logic [DATA_W-1:0]  dac_code_o,
  output term_e              term_o
);
  localparam int PAY_W = FRAME_W - OP_W;

  logic [FRAME_W-1:0] in_q, in_d;
  logic               lat_vld_q;
  logic [DATA_W-1:0]  code_q, code_d;
  term_e              term_q, term_d;
  logic [OP_W-1:0]    op;
  logic [DATA_W-1:0]  field;
  logic [1:0]         sel;

  assign op  = in_q[FRAME_W-1 -: OP_W];
  assign sel = in_q[1:0];

  if (DATA_W == PAY_W) begin : g_full
    assign field = in_q[PAY_W-1:0];
  end else begin : g_left
    assign field = in_q[PAY_W-1 -: DATA_W];
  end

  always_comb begin
    in_d = word_vld_i ? word_i : in_q;
  end

  always_comb begin
    code_d = code_q;
    term_d = term_q;
    if (lat_vld_q) begin
      case (op)
        OP_LOAD: code_d = field;
        OP_TERM: term_d = term_e'(sel);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q      <= '0;
      lat_vld_q <= 1'b0;
      code_q    <= '0;
      term_q    <= TERM_DRIVE;
    end else begin
      in_q      <= in_d;
      lat_vld_q <= word_vld_i;
      code_q    <= code_d;
      term_q    <= term_d;
    end
  end

  assign dac_code_o = code_q;
  assign term_o     = term_q;

  // R2
  load_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_vld_q && op == OP_LOAD) |=> (code_q == $past(field) && $stable(term_q)));

  // R4
  term_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_vld_q && op == OP_TERM) |=> (term_q == term_e'($past(sel)) && $stable(code_q)));

  // R5
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_vld_q && op != OP_LOAD && op != OP_TERM) |=> ($stable(code_q) && $stable(term_q)));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_vld_q |=> ($stable(code_q) && $stable(term_q)));
endmodule

// File: rtl/serdac_cmd_if.sv
module serdac_cmd_if
  import serdac_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [1:0]        out_mode_o
);
  logic               rst_n_s;
  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] word;
  logic               word_vld;
  term_e              term;

  serdac_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_s)
  );

  serdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({cs_n_i, sclk_i, sdin_i}),
    .q     (pins_s)
  );

  serdac_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cs_n_s     (pins_s[2]),
    .sclk_s     (pins_s[1]),
    .sdin_s     (pins_s[0]),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  serdac_decode #(.DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .word_i     (word),
    .word_vld_i (word_vld),
    .dac_code_o (dac_code_o),
    .term_o     (term)
  );

  assign out_mode_o = term;
endmodule

// File: tb/serdac_cmd_if_tb.sv
module serdac_cmd_if_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic [11:0] code12;
  logic [9:0]  code10;
  logic [7:0]  code8;
  logic [1:0]  mode12, mode10, mode8;

  logic [11:0] exp12 = '0;
  logic [9:0]  exp10 = '0;
  logic [7:0]  exp8  = '0;
  logic [1:0]  expm  = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serdac_cmd_if #(.DATA_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdin_i(sdin),
    .dac_code_o(code12), .out_mode_o(mode12));
  serdac_cmd_if #(.DATA_W(10)) u_dut10 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdin_i(sdin),
    .dac_code_o(code10), .out_mode_o(mode10));
  serdac_cmd_if #(.DATA_W(8)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdin_i(sdin),
    .dac_code_o(code8), .out_mode_o(mode8));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, int'(code12), int'(exp12));
    chk({tag, "/R3 10b"}, int'(code10), int'(exp10));
    chk({tag, "/R3 8b"}, int'(code8), int'(exp8));
    chk({tag, " mode"}, int'(mode12), int'(expm));
    chk({tag, " mode10"}, int'(mode10), int'(expm));
    chk({tag, " mode8"}, int'(mode8), int'(expm));
  endtask

  task automatic model(logic [15:0] w);
    if (w[15:12] == 4'h0) begin
      exp12 = w[11:0];
      exp10 = w[11:2];
      exp8  = w[11:4];
    end else if (w[15:12] == 4'hF) begin
      expm = w[1:0];
    end
  endtask

  task automatic send_bits(logic [15:0] w, int n);
    for (int i = 15; i > 15 - n; i--) begin
      sdin = w[i];
      tick(3);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(4);
    end
  endtask

  task automatic send_word(logic [15:0] w);
    cs_n = 1'b0;
    tick(3);
    send_bits(w, 16);
    tick(4);
    cs_n = 1'b1;
    tick(10);
    model(w);
  endtask

  task automatic t_reset;
    check_all("R1 reset");
  endtask

  task automatic t_load;
    logic [15:0] ws [5] = '{16'h0ABC, 16'h0FFF, 16'h0001, 16'h000E, 16'h0553};
    foreach (ws[i]) begin
      send_word(ws[i]);
      check_all("R2 load");
    end
  endtask

  task automatic t_mode;
    logic [15:0] ws [4] = '{16'hF001, 16'hF6A2, 16'hF003, 16'hF000};
    foreach (ws[i]) begin
      send_word(ws[i]);
      check_all("R4 mode");
    end
  endtask

  task automatic t_ignore;
    logic [15:0] ws [4] = '{16'h5123, 16'h1FFF, 16'hE003, 16'h8002};
    foreach (ws[i]) begin
      send_word(ws[i]);
      check_all("R5 ignored op");
    end
  endtask

  task automatic t_abort;
    cs_n = 1'b0;
    tick(3);
    send_bits(16'h0777, 10);
    cs_n = 1'b1;
    tick(12);
    check_all("R6 abort");
    send_word(16'h0321);
    check_all("R6 next word");
  endtask

  task automatic t_short;
    cs_n = 1'b0;
    tick(3);
    send_bits(16'h0456, 15);
    tick(12);
    check_all("R9 fifteen edges");
    cs_n = 1'b1;
    tick(12);
    check_all("R9 after release");
  endtask

  task automatic t_extra;
    cs_n = 1'b0;
    tick(3);
    send_bits(16'h0246, 16);
    send_bits(16'h0999, 16);
    tick(4);
    cs_n = 1'b1;
    tick(10);
    model(16'h0246);
    check_all("R7 trailing edges");
    send_word(16'h0135);
    check_all("R7 rearmed");
  endtask

  task automatic t_gated;
    sdin = 1'b1;
    for (int i = 0; i < 7; i++) begin
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(4);
    end
    check_all("R8 idle edges");
    send_word(16'h0AAA);
    check_all("R8 word after idle edges");
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(6);
    t_reset();
    t_load();
    t_mode();
    t_ignore();
    t_abort();
    t_short();
    t_extra();
    t_gated();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule